// File: doc/BRIEF.md
# External Memory Bus Strobe Sequencer

This block produces the external-bus control timing of a classic 8-bit microcontroller core. Each machine cycle lasts 12 oscillator clocks, split into 6 states of 2 phases each. In every cycle the sequencer generates the following:

- the address-latch strobe;
- the active-low program-read strobe;
- the low port, which carries the low address byte and then turns around to carry data;
- the high port, which carries the high address byte or the port's own register contents.

The core presents one request per machine cycle. The request gives:

- the cycle kind: opcode fetch, data move through a 16-bit pointer, data move through an 8-bit pointer, or code-constant read;
- the address and the write data;
- the high-port register value;
- an address-latch disable bit;
- an external-execution flag.

The request is taken on the last clock of the running cycle, flagged by `req_take_o`. It drives the whole next cycle. In a fetch or code-read cycle the address-latch strobe pulses twice, which is one pulse every 6 clocks. A data-move cycle drops the second latch pulse and both program-read assertions. The disable bit silences the latch strobe in fetch cycles, but not while executing from external program memory.

Top module: `ebus_strobe_seq`

## Requirements
- R1: While reset is held: `ale_o`=0, `ale_oe_o`=1, `psen_n_o`=1, `p0_oe_o`=0, `p2_o`=0, `p2_strong_o`=0, `req_take_o`=0.
- R2: A machine cycle is 12 clocks, with phases 0..11. `req_take_o` is high only in phase 11. The inputs sampled at that clock edge govern the entire next cycle.
- R3: In fetch (`cyc_type_i`=0) and code-read (`cyc_type_i`=3) cycles, the latch strobe is high in phases 1, 2, 7 and 8. That is two pulses per cycle, one every 6 clocks.
- R4: In data-move cycles (`cyc_type_i`=1 for a 16-bit pointer, 2 for an 8-bit pointer), the latch strobe pulses only in phases 1 and 2, and `psen_n_o` stays high.
- R5: In fetch and code-read cycles with `ext_exec_i`=1, `psen_n_o` is low in phases 4, 5, 10 and 11, which is two assertions per cycle. With `ext_exec_i`=0 it stays high.
- R6: In a fetch cycle with `ale_dis_i`=1 and `ext_exec_i`=0, the latch strobe is not driven (`ale_oe_o`=0) and reads high (`ale_o`=1), so no pulses occur. Data-move and code-read cycles still pulse normally, with `ale_oe_o`=1.
- R7: With `ext_exec_i`=1, `ale_dis_i` has no effect: fetch cycles pulse exactly as in R3.
- R8: The low port drives `addr_i[7:0]` in phases 0..3 of each external access. For external fetch and code-read cycles it also drives it in phases 6..9. The address is therefore stable across each falling edge of the latch strobe, and the port floats while `psen_n_o` is low.
- R9: In a data-move cycle, the low port drives `wdata_i` in phases 4..11 when `wr_i`=1. When `wr_i`=0 it floats in those phases.
- R10: `p2_o` carries `addr_i[15:8]` in 16-bit-pointer data moves and in external fetch and code-read cycles. In all other cycles, including 8-bit-pointer data moves, it carries `p2_reg_i`.
- R11: `p2_strong_o` marks the bits of `p2_o` that are 1 while the port emits an address. It is all zero when the port shows its register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cyc_type_i | input | 2 | Kind of the next cycle: 0 fetch, 1 data move 16-bit pointer, 2 data move 8-bit pointer, 3 code read |
| ext_exec_i | input | 1 | Core executes from external program memory |
| ale_dis_i | input | 1 | Address-latch disable bit |
| wr_i | input | 1 | Data move is a write |
| addr_i | input | 16 | Bus address of the next cycle |
| wdata_i | input | 8 | Write data for a data move |
| p2_reg_i | input | 8 | Contents of the high port register |
| req_take_o | output | 1 | Last clock of the cycle; request sampled at its end |
| ale_o | output | 1 | Address-latch strobe level |
| ale_oe_o | output | 1 | Latch strobe strongly driven (0 = weak pull-up) |
| psen_n_o | output | 1 | Program-read strobe, active low |
| p0_o | output | 8 | Low port output value |
| p0_oe_o | output | 1 | Low port drive enable |
| p2_o | output | 8 | High port output value |
| p2_strong_o | output | 8 | Per-bit strong drive of the high port |

## Verification
The bench captures every output over all 12 phases of a machine cycle and compares the captured masks and pulse counts with the expected pattern for each cycle kind. Internal and external fetches differ only in the program-read strobe, the low-port drive and the high-port source. Writes and reads through the two pointer widths differ in the low-port data phase and in the high-port source. Three patterns exercise the disable bit:

- with an internal fetch, where it must silence the latch strobe;
- with a code read and a data move, where it must not;
- with external execution, where it must be overridden.

// File: rtl/ebus_seq_pkg.sv
package ebus_seq_pkg;
  parameter int unsigned ADDR_W    = 16;
  parameter int unsigned DATA_W    = 8;
  parameter int unsigned STATES    = 6;
  parameter int unsigned PH_PER_ST = 2;

  localparam int unsigned CYC_LEN = STATES * PH_PER_ST;
  localparam int unsigned HALF    = CYC_LEN / 2;
  localparam int unsigned PH_W    = $clog2(CYC_LEN);
  localparam int unsigned HI_W    = ADDR_W - DATA_W;

  typedef logic [PH_W-1:0] ph_t;

  // positions inside each half cycle
  localparam ph_t PH_LAST = ph_t'(CYC_LEN - 1);
  localparam ph_t PH_HALF = ph_t'(HALF);
  localparam ph_t ALE_ON  = ph_t'(1);
  localparam ph_t ALE_OFF = ph_t'(3);
  localparam ph_t ADR_END = ph_t'(4);
  localparam ph_t RD_ON   = ph_t'(HALF - 2);

  typedef enum logic [1:0] {
    CYC_FETCH  = 2'd0,
    CYC_MOVX16 = 2'd1,
    CYC_MOVX8  = 2'd2,
    CYC_MOVC   = 2'd3
  } cyc_e;

  typedef struct packed {
    cyc_e              kind;
    logic              ext;
    logic              ale_dis;
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [HI_W-1:0]   p2reg;
  } req_t;
endpackage

// File: rtl/ebus_phase_ctr.sv
module ebus_phase_ctr
  import ebus_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  output ph_t  sub_o,
  output logic second_o,
  output logic last_o
);
  ph_t ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              ph_q <= '0;
    else if (ph_q == PH_LAST) ph_q <= '0;
    else                      ph_q <= ph_q + ph_t'(1);
  end

  assign second_o = (ph_q >= PH_HALF);
  assign sub_o    = second_o ? ph_q - PH_HALF : ph_q;
  assign last_o   = (ph_q == PH_LAST);

  // R2
  cyc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (sub_o == '0) && !second_o);
  // R2
  last_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !last_o);
endmodule

// File: rtl/ebus_req_reg.sv
module ebus_req_reg
  import ebus_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  req_t req_i,
  output req_t req_o
);
  req_t req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_q <= '{kind: CYC_FETCH, default: '0};
    else if (take_i) req_q <= req_i;
  end

  assign req_o = req_q;

  // R2
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> $stable(req_q));
endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
  import ebus_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  ph_t  sub_i,
  input  logic second_i,
  input  req_t req_i,
  output logic code_bus_o,
  output logic data_bus_o,
  output logic ale_o,
  output logic ale_oe_o,
  output logic psen_n_o
);
  logic suppress, ale_win, ale_pulse;

  always_comb begin
    code_bus_o = ((req_i.kind == CYC_FETCH) || (req_i.kind == CYC_MOVC)) && req_i.ext;
    data_bus_o = (req_i.kind == CYC_MOVX16) || (req_i.kind == CYC_MOVX8);
    // disable bit only bites on fetches, and never in external execution
    suppress   = req_i.ale_dis && !req_i.ext && (req_i.kind == CYC_FETCH);
    ale_win    = (sub_i >= ALE_ON) && (sub_i < ALE_OFF);
    ale_pulse  = ale_win && !(second_i && data_bus_o);
    ale_o      = suppress ? 1'b1 : ale_pulse;
    ale_oe_o   = !suppress;
    psen_n_o   = !(code_bus_o && (sub_i >= RD_ON));
  end

  // R4
  movx_no_psen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_bus_o |-> psen_n_o);
  // R4
  movx_one_ale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_bus_o && second_i) |-> !ale_o);
  // R5
  ale_psen_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && ale_oe_o && !psen_n_o));
  // R7
  ext_ale_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i.ext |-> ale_oe_o);
endmodule

// File: rtl/ebus_port_mux.sv
module ebus_port_mux
  import ebus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ph_t               sub_i,
  input  logic              second_i,
  input  req_t              req_i,
  input  logic              code_bus_i,
  input  logic              data_bus_i,
  input  logic              ale_i,
  input  logic              ale_oe_i,
  input  logic              psen_n_i,
  output logic [DATA_W-1:0] p0_o,
  output logic              p0_oe_o,
  output logic [HI_W-1:0]   p2_o,
  output logic [HI_W-1:0]   p2_strong_o
);
  logic adr_win, p2_addr;

  always_comb begin
    adr_win = (sub_i < ADR_END);
    p0_o    = '0;
    p0_oe_o = 1'b0;
    if (adr_win && (code_bus_i || (data_bus_i && !second_i))) begin
      p0_o    = req_i.addr[DATA_W-1:0];
      p0_oe_o = 1'b1;
    end else if (data_bus_i && req_i.wr) begin
      p0_o    = req_i.wdata;
      p0_oe_o = 1'b1;
    end
  end

  assign p2_addr     = code_bus_i || (req_i.kind == CYC_MOVX16);
  assign p2_o        = p2_addr ? req_i.addr[ADDR_W-1:DATA_W] : req_i.p2reg;
  assign p2_strong_o = p2_addr ? p2_o : '0;

  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ale_i) && ale_oe_i && $past(p0_oe_o)) |-> (p0_oe_o && $stable(p0_o)));
  // R8
  p0_float_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_n_i |-> !p0_oe_o);
  // R11
  strong_subset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p2_strong_o & ~p2_o) == '0);
endmodule

// File: rtl/ebus_strobe_seq.sv
module ebus_strobe_seq
  import ebus_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        cyc_type_i,
  input  logic              ext_exec_i,
  input  logic              ale_dis_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [HI_W-1:0]   p2_reg_i,
  output logic              req_take_o,
  output logic              ale_o,
  output logic              ale_oe_o,
  output logic              psen_n_o,
  output logic [DATA_W-1:0] p0_o,
  output logic              p0_oe_o,
  output logic [HI_W-1:0]   p2_o,
  output logic [HI_W-1:0]   p2_strong_o
);
  ph_t  sub;
  logic second, last, code_bus, data_bus;
  req_t req_in, req_cur;

  assign req_in = '{kind: cyc_e'(cyc_type_i), ext: ext_exec_i, ale_dis: ale_dis_i,
                    wr: wr_i, addr: addr_i, wdata: wdata_i, p2reg: p2_reg_i};

  ebus_phase_ctr u_ctr (
    .clk_i, .rst_ni, .sub_o(sub), .second_o(second), .last_o(last)
  );

  ebus_req_reg u_req (
    .clk_i, .rst_ni, .take_i(last), .req_i(req_in), .req_o(req_cur)
  );

  ebus_strobe_gen u_strb (
    .clk_i, .rst_ni, .sub_i(sub), .second_i(second), .req_i(req_cur),
    .code_bus_o(code_bus), .data_bus_o(data_bus),
    .ale_o, .ale_oe_o, .psen_n_o
  );

  ebus_port_mux u_port (
    .clk_i, .rst_ni, .sub_i(sub), .second_i(second), .req_i(req_cur),
    .code_bus_i(code_bus), .data_bus_i(data_bus),
    .ale_i(ale_o), .ale_oe_i(ale_oe_o), .psen_n_i(psen_n_o),
    .p0_o, .p0_oe_o, .p2_o, .p2_strong_o
  );

  assign req_take_o = last;

  // R6
  dis_fetch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_oe_o) |-> (ale_o && psen_n_o && !p0_oe_o));
endmodule

// File: tb/tb_ebus_strobe_seq.sv
module tb_ebus_strobe_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CYC = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] cyc_type_i = 2'd0;
  logic ext_exec_i = 1'b0, ale_dis_i = 1'b0, wr_i = 1'b0;
  logic [15:0] addr_i = '0;
  logic [7:0] wdata_i = '0, p2_reg_i = '0;
  logic req_take_o, ale_o, ale_oe_o, psen_n_o, p0_oe_o;
  logic [7:0] p0_o, p2_o, p2_strong_o;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ebus_strobe_seq dut (
    .clk_i(clk), .rst_ni, .cyc_type_i, .ext_exec_i, .ale_dis_i, .wr_i,
    .addr_i, .wdata_i, .p2_reg_i, .req_take_o, .ale_o, .ale_oe_o,
    .psen_n_o, .p0_o, .p0_oe_o, .p2_o, .p2_strong_o
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_reset();
    // R1
    chk(ale_o == 0 && ale_oe_o == 1, "R1 ale reset", {ale_o, ale_oe_o}, 2'b01);
    chk(psen_n_o == 1 && p0_oe_o == 0, "R1 psen/p0 reset", {psen_n_o, p0_oe_o}, 2'b10);
    chk(p2_o == 0 && p2_strong_o == 0 && req_take_o == 0, "R1 p2/take reset",
        {p2_o, p2_strong_o, 7'd0, req_take_o}, 0);
  endtask

  // drives one request and checks the machine cycle it governs
  task automatic run_cycle(input logic [1:0] kind, input bit ext, input bit dis, input bit wr,
                           input logic [15:0] addr, input logic [7:0] wd, input logic [7:0] p2r);
    logic [11:0] ale_m, oe_m, psen_m, p0oe_m, take_m;
    logic [7:0]  p0_s[CYC];
    logic [7:0]  p2_s, st_s;
    int ale_cnt, psen_cnt;
    bit code, data, sup, p2a;
    logic [11:0] exp_ale, exp_psen, exp_p0oe;
    string tag;
    while (!req_take_o) @(negedge clk);
    cyc_type_i = kind; ext_exec_i = ext; ale_dis_i = dis; wr_i = wr;
    addr_i = addr; wdata_i = wd; p2_reg_i = p2r;
    for (int k = 0; k < CYC; k++) begin
      @(negedge clk);
      ale_m[k]  = ale_o & ale_oe_o;
      oe_m[k]   = ale_oe_o;
      psen_m[k] = ~psen_n_o;
      p0oe_m[k] = p0_oe_o;
      take_m[k] = req_take_o;
      p0_s[k]   = p0_o;
      if (k == 5) begin p2_s = p2_o; st_s = p2_strong_o; end
      if (!ale_oe_o && !ale_o) chk(0, "R6 weak level high", ale_o, 1);
    end
    ale_cnt = 0; psen_cnt = 0;
    for (int k = 0; k < CYC; k++) begin
      if (ale_m[k] && (k == 0 || !ale_m[k-1])) ale_cnt++;
      if (psen_m[k] && (k == 0 || !psen_m[k-1])) psen_cnt++;
    end
    code = (kind == 2'd0 || kind == 2'd3) && ext;
    data = (kind == 2'd1 || kind == 2'd2);
    sup  = dis && !ext && kind == 2'd0;
    p2a  = code || kind == 2'd1;
    exp_ale  = sup ? 12'h000 : (data ? 12'h006 : 12'h186);
    exp_psen = code ? 12'hC30 : 12'h000;
    exp_p0oe = code ? 12'h3CF : (data ? (wr ? 12'hFFF : 12'h00F) : 12'h000);
    tag = sup ? "R6" : (dis ? (ext ? "R7" : "R6") : (data ? "R4" : "R3"));
    // R2
    chk(take_m == 12'h800, "R2 take position", take_m, 12'h800);
    chk(ale_cnt == (sup ? 0 : (data ? 1 : 2)), {tag, " ale pulse count"}, ale_cnt,
        sup ? 0 : (data ? 1 : 2));
    chk(ale_m == exp_ale, {tag, " ale phase mask"}, ale_m, exp_ale);
    chk(oe_m == (sup ? 12'h000 : 12'hFFF), {tag, " ale drive"}, oe_m, sup ? 0 : 12'hFFF);
    // R5 (R4 for data moves)
    chk(psen_m == exp_psen && psen_cnt == (code ? 2 : 0),
        data ? "R4 psen mask" : "R5 psen mask", psen_m, exp_psen);
    // R8 / R9
    chk(p0oe_m == exp_p0oe, data ? "R9 p0 drive mask" : "R8 p0 drive mask", p0oe_m, exp_p0oe);
    if (code || data)
      chk(p0_s[2] == addr[7:0] && p0_s[3] == addr[7:0], "R8 addr at ale fall", p0_s[3], addr[7:0]);
    if (code)
      chk(p0_s[8] == addr[7:0] && p0_s[9] == addr[7:0], "R8 addr at 2nd fall", p0_s[9], addr[7:0]);
    if (data && wr)
      chk(p0_s[4] == wd && p0_s[11] == wd, "R9 write data", p0_s[11], wd);
    // R10 / R11
    chk(p2_s == (p2a ? addr[15:8] : p2r), "R10 high port", p2_s, p2a ? addr[15:8] : p2r);
    chk(st_s == (p2a ? addr[15:8] : 8'h00), "R11 strong mask", st_s, p2a ? addr[15:8] : 8'h00);
  endtask

  task automatic t_internal_fetch();  run_cycle(2'd0, 0, 0, 0, 16'h12A5, 8'h00, 8'h3C); endtask
  task automatic t_external_fetch();  run_cycle(2'd0, 1, 0, 0, 16'hB4E1, 8'h00, 8'h3C); endtask
  task automatic t_movx16_write();    run_cycle(2'd1, 0, 0, 1, 16'hC35A, 8'h96, 8'h0F); endtask
  task automatic t_movx8_read();      run_cycle(2'd2, 1, 0, 0, 16'h7F81, 8'hEE, 8'h5A); endtask
  task automatic t_movc_external();   run_cycle(2'd3, 1, 0, 0, 16'h0FF0, 8'h00, 8'hA5); endtask
  task automatic t_dis_fetch();       run_cycle(2'd0, 0, 1, 0, 16'h4321, 8'h00, 8'h99); endtask
  task automatic t_dis_movc();        run_cycle(2'd3, 0, 1, 0, 16'h8001, 8'h00, 8'h66); endtask
  task automatic t_dis_movx8_write(); run_cycle(2'd2, 0, 1, 1, 16'h00FE, 8'h3B, 8'hC1); endtask
  task automatic t_dis_ext_fetch();   run_cycle(2'd0, 1, 1, 0, 16'hFFFF, 8'h00, 8'h00); endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_ni = 1'b1;
    t_internal_fetch();
    t_external_fetch();
    t_movx16_write();
    t_movx8_read();
    t_movc_external();
    t_dis_fetch();
    t_dis_movc();
    t_dis_movx8_write();
    t_dis_ext_fetch();
    t_dis_fetch();
    t_internal_fetch();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule